// File: doc/BRIEF.md
# DAC Mode and Calibration Controller

This block is the control core that sits behind the register bank of a precision delta-sigma DAC. It keeps the command word, the conversion data word and the two calibration words. A serial front end hands it one finished register write at a time, as a single-cycle strobe that carries a register select and the assembled value. The block decodes the operating mode held in the command word and starts a timed self-calibration when the command asks for one. It also performs the one-shot clear and calibration-reset actions. The analog side reads the mode and register values from its outputs.

Self-calibration runs only when the command write sets the mode field to calibrate and also sets the sample/hold bit. For its whole duration, set by a parameter, the block refuses every register write. At the end it stores the results from a stubbed measurement engine. The offset result is converted to offset-binary form. The full-scale result is stored unchanged. The mode field then returns to normal by itself. Sleep is the state after reset. Leaving sleep starts a short, timed power-up interval.

Top module: `dac_mode_ctrl`

## Requirements
- R1: After reset the command word reads 0x0002 (mode field bits [1:0] = 10, sleep; every other bit 0). The data, offset and full-scale words read 0, `busy` and `waking` are low and `asleep` is high.
- R2: When `busy` is low, a write strobe with `wr_sel` 0 loads the data word, 1 loads the command word (low 16 bits), 2 loads the offset word and 3 loads the full-scale word. The new value is visible one clock later.
- R3: Mode field codes are 00 normal, 01 calibrate and 10 sleep. `asleep` is high exactly in sleep. A command write whose mode field is 11 leaves the mode field unchanged and updates the other bits.
- R4: A command write with mode field 01 and sample/hold bit 2 set raises `busy` on the next clock. With bit 2 clear, the mode field reads 01 and `busy` stays low.
- R5: `busy` stays high for exactly CAL_CYCLES clocks.
- R6: Every register write that arrives while `busy` is high is ignored.
- R7: When calibration ends, the mode field reads 00 and the other command bits are kept. The offset word holds `meas_ofs` with bit 23 inverted. The full-scale word holds `meas_fs` unchanged, whatever the data-format bit 5 holds.
- R8: A command write with the clear bit 3 set zeroes the data word. Bit 3 reads back as 0.
- R9: A command write with the calibration-reset bit 4 set zeroes both calibration words. Bit 4 reads back as 0.
- R10: A command write that moves the mode field from sleep to any other code raises `waking` for exactly WAKE_CYCLES clocks. Writes that enter or stay in sleep do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Completed register write strobe from the serial front end |
| wr_sel | input | 2 | Target register: 0 data, 1 command, 2 offset, 3 full-scale |
| wr_data | input | 24 | Assembled register value |
| meas_ofs | input | 24 | Offset measurement, two's complement, from the measurement engine |
| meas_fs | input | 24 | Full-scale measurement, unsigned, from the measurement engine |
| cmd_q | output | 16 | Command word readback |
| data_q | output | 24 | Data word to the modulator |
| ofs_q | output | 24 | Offset calibration word |
| fs_q | output | 24 | Full-scale calibration word |
| busy | output | 1 | Self-calibration in progress |
| asleep | output | 1 | Mode field is sleep |
| waking | output | 1 | Power-up interval after leaving sleep |

## Verification
The hardest case to reach is a write that lands inside the calibration window, where it must be dropped. The bench reaches it by issuing data and command writes while it counts the busy cycles. It then checks that the data word and the kept command bits are unchanged, and that the busy count is exact. The run repeats this over several measurement values, including a negative offset. Other cases sweep all four mode codes, including the undefined one, moving into and out of sleep.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam logic [1:0] MODE_NORM  = 2'b00;
  localparam logic [1:0] MODE_CAL   = 2'b01;
  localparam logic [1:0] MODE_SLEEP = 2'b10;
  localparam logic [1:0] MODE_UNDEF = 2'b11;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_OFS  = 2'd2;
  localparam logic [1:0] SEL_FS   = 2'd3;

  localparam int BIT_SH   = 2;
  localparam int BIT_CLR  = 3;
  localparam int BIT_CRST = 4;
  localparam int BIT_DF   = 5;

  // An undefined mode code keeps the present mode.
  function automatic logic [1:0] resolve_mode(input logic [1:0] cur, input logic [1:0] req);
    return (req == MODE_UNDEF) ? cur : req;
  endfunction
endpackage

// File: rtl/dac_downcount.sv
module dac_downcount #(
  parameter int N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active,
  output logic last
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] NV = CW'(N);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= NV;
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
  assign last   = (cnt == CW'(1));

  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n) cnt <= NV);
  p_load_fills_r5: assert property (@(posedge clk) disable iff (!rst_n) load |=> cnt == NV);
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_ctrl_pkg::*;
#(
  parameter int CMD_W = 16
) (
  input  logic             cmd_wr,
  input  logic [1:0]       cur_mode,
  input  logic [CMD_W-1:0] wd,
  output logic [CMD_W-1:0] next_cmd,
  output logic             cal_go,
  output logic             wake_go,
  output logic             clr_go,
  output logic             crst_go
);
  logic [1:0] new_mode;

  always_comb begin
    new_mode = resolve_mode(cur_mode, wd[1:0]);
    next_cmd = wd;
    next_cmd[1:0]    = new_mode;
    next_cmd[BIT_CLR]  = 1'b0;
    next_cmd[BIT_CRST] = 1'b0;
    cal_go  = cmd_wr && (new_mode == MODE_CAL) && wd[BIT_SH];
    wake_go = cmd_wr && (cur_mode == MODE_SLEEP) && (new_mode != MODE_SLEEP);
    clr_go  = cmd_wr && wd[BIT_CLR];
    crst_go = cmd_wr && wd[BIT_CRST];
  end
endmodule

// File: rtl/dac_mode_ctrl.sv
module dac_mode_ctrl
  import dac_ctrl_pkg::*;
#(
  parameter int CMD_W       = 16,
  parameter int REG_W       = 24,
  parameter int CAL_CYCLES  = 750000,
  parameter int WAKE_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [REG_W-1:0] meas_ofs,
  input  logic [REG_W-1:0] meas_fs,
  output logic [CMD_W-1:0] cmd_q,
  output logic [REG_W-1:0] data_q,
  output logic [REG_W-1:0] ofs_q,
  output logic [REG_W-1:0] fs_q,
  output logic             busy,
  output logic             asleep,
  output logic             waking
);
  localparam logic [CMD_W-1:0] CMD_RESET = {{(CMD_W-2){1'b0}}, MODE_SLEEP};

  // Offset result: two's complement to offset binary.
  function automatic logic [REG_W-1:0] ofs_code(input logic [REG_W-1:0] m);
    return {~m[REG_W-1], m[REG_W-2:0]};
  endfunction

  logic             accept;
  logic             cmd_wr;
  logic [CMD_W-1:0] next_cmd;
  logic             cal_go, wake_go, clr_go, crst_go;
  logic             cal_active, cal_last;
  logic             wake_last;

  assign accept = wr_en && !busy;
  assign cmd_wr = accept && (wr_sel == SEL_CMD);

  dac_cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .cmd_wr   (cmd_wr),
    .cur_mode (cmd_q[1:0]),
    .wd       (wr_data[CMD_W-1:0]),
    .next_cmd (next_cmd),
    .cal_go   (cal_go),
    .wake_go  (wake_go),
    .clr_go   (clr_go),
    .crst_go  (crst_go)
  );

  dac_downcount #(.N(CAL_CYCLES)) u_cal_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cal_go),
    .active (cal_active),
    .last   (cal_last)
  );

  dac_downcount #(.N(WAKE_CYCLES)) u_wake_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (wake_go),
    .active (waking),
    .last   (wake_last)
  );

  assign busy   = cal_active;
  assign asleep = (cmd_q[1:0] == MODE_SLEEP);

  always_ff @(posedge clk) begin
    if (!rst_n)        cmd_q <= CMD_RESET;
    else if (cal_last) cmd_q[1:0] <= MODE_NORM;
    else if (cmd_wr)   cmd_q <= next_cmd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              data_q <= '0;
    else if (clr_go)                         data_q <= '0;
    else if (accept && wr_sel == SEL_DATA)   data_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q <= '0;
      fs_q  <= '0;
    end else if (cal_last) begin
      ofs_q <= ofs_code(meas_ofs);
      fs_q  <= meas_fs;
    end else if (crst_go) begin
      ofs_q <= '0;
      fs_q  <= '0;
    end else if (accept) begin
      if (wr_sel == SEL_OFS) ofs_q <= wr_data;
      if (wr_sel == SEL_FS)  fs_q  <= wr_data;
    end
  end

  p_no_undef_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_q[1:0] != MODE_UNDEF);
  p_cal_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_sel == SEL_CMD && wr_data[1:0] == MODE_CAL && wr_data[BIT_SH]) |=> busy);
  p_write_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_sel == SEL_DATA) |=> $stable(data_q));
  p_cal_end_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cmd_q[1:0] == MODE_NORM);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_sel == SEL_CMD && wr_data[BIT_CLR]) |=> data_q == '0);
  p_cal_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_sel == SEL_CMD && wr_data[BIT_CRST]) |=> (ofs_q == '0 && fs_q == '0));
  p_wake_from_sleep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(waking) |-> $past(cmd_q[1:0]) == MODE_SLEEP);
  p_wake_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_last && !wake_go) |=> !waking);
endmodule

// File: tb/dac_mode_ctrl_bench.sv
`timescale 1ns/1ps
module dac_mode_ctrl_bench;
  localparam int CALN  = 20;
  localparam int WAKEN = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [23:0] wr_data = '0;
  logic [23:0] meas_ofs = '0;
  logic [23:0] meas_fs = '0;
  logic [15:0] cmd_q;
  logic [23:0] data_q, ofs_q, fs_q;
  logic        busy, asleep, waking;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dac_mode_ctrl #(.CAL_CYCLES(CALN), .WAKE_CYCLES(WAKEN)) u_dac_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .meas_ofs(meas_ofs), .meas_fs(meas_fs), .cmd_q(cmd_q), .data_q(data_q),
    .ofs_q(ofs_q), .fs_q(fs_q), .busy(busy), .asleep(asleep), .waking(waking)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_waking(output int n);
    n = 0;
    while (waking && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int n;
    logic [23:0] pat;
    logic [23:0] om [3];
    logic [23:0] fm [3];
    om[0] = 24'h000123; om[1] = 24'hFFFFF0; om[2] = 24'h7FFFFF;
    fm[0] = 24'h7ABCDE; fm[1] = 24'hC00001; fm[2] = 24'h000000;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd", cmd_q, 32'h0002);
    chk("R1 data", data_q, 0);
    chk("R1 ofs", ofs_q, 0);
    chk("R1 fs", fs_q, 0);
    chk("R1 busy", busy, 0);
    chk("R1 waking", waking, 0);
    chk("R1 asleep", asleep, 1);

    // R10 leave sleep
    wr(2'd1, 24'h000000);
    chk("R10 asleep cleared", asleep, 0);
    count_waking(n);
    chk("R10 wake length", n, WAKEN);

    // R2 register write sweep
    for (int i = 0; i < 8; i++) begin
      pat = (24'hA5A5A5 >> i) ^ (24'h010203 * i);
      wr(2'd0, pat);        chk("R2 data", data_q, pat);
      wr(2'd2, pat ^ 24'hFFFFFF); chk("R2 ofs", ofs_q, pat ^ 24'hFFFFFF);
      wr(2'd3, pat + 24'd7); chk("R2 fs", fs_q, pat + 24'd7);
    end
    wr(2'd1, 24'h00C0);
    chk("R2 cmd", cmd_q, 32'h00C0);

    // R3 mode codes
    wr(2'd1, 24'h0043);
    chk("R3 undef from normal", cmd_q, 32'h0040);
    wr(2'd1, 24'h0002);
    chk("R3 asleep", asleep, 1);
    chk("R10 entering sleep no wake", waking, 0);
    wr(2'd1, 24'h0083);
    chk("R3 undef keeps sleep", cmd_q, 32'h0082);
    chk("R3 still asleep", asleep, 1);
    chk("R10 staying asleep no wake", waking, 0);
    wr(2'd1, 24'h0000);
    chk("R3 normal", asleep, 0);
    count_waking(n);
    chk("R10 wake again", n, WAKEN);

    // R8 clear
    wr(2'd0, 24'h13579B);
    wr(2'd1, 24'h0008);
    chk("R8 data zeroed", data_q, 0);
    chk("R8 clr bit reads 0", cmd_q, 32'h0000);

    // R4 calibrate without sample/hold
    wr(2'd1, 24'h0001);
    chk("R4 no busy without sh", busy, 0);
    chk("R4 mode 01 kept", cmd_q, 32'h0001);

    // R4..R7 calibration sweep
    wr(2'd0, 24'h2468AC);
    for (int k = 0; k < 3; k++) begin
      meas_ofs = om[k];
      meas_fs  = fm[k];
      wr(2'd1, 24'h0025);
      chk("R4 busy after start", busy, 1);
      n = 0;
      while (busy && n < 1000) begin
        n++;
        if (n == 2) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = 24'h0BAD00; end
        if (n == 3) begin wr_sel = 2'd1; wr_data = 24'h0002; end
        if (n == 4) begin wr_sel = 2'd2; wr_data = 24'h00BEEF; end
        if (n == 5) wr_en = 1'b0;
        @(negedge clk);
      end
      chk("R5 busy length", n, CALN);
      chk("R6 data kept", data_q, 32'h2468AC);
      chk("R7 mode normal", cmd_q, 32'h0024);
      chk("R7 offset code", ofs_q, om[k] ^ 24'h800000);
      chk("R7 fullscale raw", fs_q, fm[k]);
      chk("R6 no wake", waking, 0);
    end

    // R9 calibration reset
    wr(2'd1, 24'h0010);
    chk("R9 ofs zero", ofs_q, 0);
    chk("R9 fs zero", fs_q, 0);
    chk("R9 bit reads 0", cmd_q, 32'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule